// File: doc/BRIEF.md
# Key-Unlocked Configuration Register Port

This block is a small indexed configuration space for a legacy I/O peripheral. It sits on a byte-wide I/O bus with an address, a write strobe, a read strobe and write and read data. Two consecutive addresses are decoded. The lower one is the index port and the upper one is the data port. Software writes a register number to the index port. It then reads or writes that register through the data port.

The space stays locked after reset. While it is locked, index-port writes only feed a key matcher, and every other access is ignored. A fixed four-byte key unlocks it. The last key byte depends on which of two port addresses the instance decodes. Writing 0x02 to register 0x02 locks the space again.

Once unlocked, the space exposes the following registers:
- a 16-bit chip identifier;
- a logical-device select register;
- with the GPIO device selected, a 16-bit runtime base address and per-pin direction registers.

The base address and the direction bits are exported as registered outputs for the runtime GPIO logic.

Top module: `cfg_key_port`

## Requirements
- R1: After reset the space is locked, `gpio_dir` is all zero (every pin an input) and `rt_base` equals the parameter `DEF_BASE` (default 0x0A00).
- R2: Four consecutive index-port writes unlock the space: 0x87, 0x61, 0x55, then a final byte. The final byte is 0x55 when `PORT_ADDR` is 0x2E and 0xAA when it is 0x4E. Any other final byte leaves the space locked.
- R3: A wrong byte in the key sequence sends the matcher back to its first step. If that wrong byte is 0x87, the matcher instead continues at its second step.
- R4: While locked, data-port writes change no register, and reads on either port return 0xFF.
- R5: Once unlocked, register 0x20 reads 0x87 and register 0x21 reads 0x61 (chip identifier 0x8761). Both are read-only.
- R6: Register 0x07 is a read/write device select. The registers at 0x60, 0x61, 0xF0 and 0xF1 are only reachable while it holds 0x02. Otherwise they read 0x00 and writes to them are discarded, as are writes to any unimplemented index.
- R7: Register 0x60 is the high byte and 0x61 the low byte of `rt_base`. Both read back what was written.
- R8: Register 0xF0 drives `gpio_dir[7:0]` and 0xF1 drives `gpio_dir[15:8]`. A bit of 1 marks that pin as an output. Both registers read back what was written.
- R9: Writing data 0x02 to index 0x02 locks the space again, and the full key is needed to reopen it. Any other data value written to index 0x02 leaves it unlocked.
- R10: `io_rdata` is loaded on the clock edge that samples a read strobe on the index or data port. An unlocked index-port read returns the current index. Bus cycles at any other address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O bus address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| rt_base | output | 16 | Runtime GPIO window base address |
| gpio_dir | output | 16 | Per-pin direction, 1 = output |

## Verification
The assertions check four things on every cycle. The direction and base outputs stay frozen while the space is locked. A locked read yields 0xFF. The identifier bytes come back whenever they are indexed. The key's final byte and the 0x02/0x02 write switch the lock exactly one cycle later. Other behaviour needs the bench's scenarios. These cover the key matcher's recovery paths, including the 0x87 restart, sweeps over every value of the final key byte at both port addresses, and every direction value in both banks. They also cover gating by the device select and the relock with its near-miss data value.

// File: rtl/cfg_key_pkg.sv
package cfg_key_pkg;
  localparam logic [7:0] KEY_B0 = 8'h87;
  localparam logic [7:0] KEY_B1 = 8'h61;
  localparam logic [7:0] KEY_B2 = 8'h55;
  localparam logic [7:0] KEY_LAST_LO = 8'h55;
  localparam logic [7:0] KEY_LAST_HI = 8'hAA;

  localparam logic [7:0] IDX_EXIT  = 8'h02;
  localparam logic [7:0] EXIT_VAL  = 8'h02;
  localparam logic [7:0] IDX_DEV   = 8'h07;
  localparam logic [7:0] IDX_ID_HI = 8'h20;
  localparam logic [7:0] IDX_ID_LO = 8'h21;
  localparam logic [7:0] IDX_BA_HI = 8'h60;
  localparam logic [7:0] IDX_BA_LO = 8'h61;
  localparam logic [7:0] IDX_DIR0  = 8'hF0;
  localparam logic [7:0] DEV_GPIO  = 8'h02;
  localparam logic [7:0] LOCKED_RD = 8'hFF;

  typedef enum logic [1:0] {
    KS_WAIT0 = 2'd0,
    KS_WAIT1 = 2'd1,
    KS_WAIT2 = 2'd2,
    KS_WAIT3 = 2'd3
  } key_step_t;
endpackage

// File: rtl/cfg_key_matcher.sv
module cfg_key_matcher
  import cfg_key_pkg::*;
#(
  parameter logic [7:0] LAST_BYTE = 8'h55
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  input  logic       relock,
  output logic       open
);
  key_step_t  step_q;
  logic [7:0] want;

  always_comb begin
    case (step_q)
      KS_WAIT0: want = KEY_B0;
      KS_WAIT1: want = KEY_B1;
      KS_WAIT2: want = KEY_B2;
      default:  want = LAST_BYTE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= KS_WAIT0;
      open   <= 1'b0;
    end else if (relock) begin
      step_q <= KS_WAIT0;
      open   <= 1'b0;
    end else if (!open && byte_vld) begin
      if (byte_in == want) begin
        if (step_q == KS_WAIT3) begin
          open   <= 1'b1;
          step_q <= KS_WAIT0;
        end else begin
          step_q <= key_step_t'(step_q + 2'd1);
        end
      end else if (byte_in == KEY_B0) begin
        step_q <= KS_WAIT1;
      end else begin
        step_q <= KS_WAIT0;
      end
    end
  end

  a_r2_final_byte_opens: assert property (@(posedge clk) disable iff (rst)
    (!open && byte_vld && !relock && step_q == KS_WAIT3 && byte_in == LAST_BYTE) |=> open);

  a_r3_wrong_0x87_restarts: assert property (@(posedge clk) disable iff (rst)
    (!open && byte_vld && !relock && byte_in == KEY_B0 && step_q != KS_WAIT0)
      |=> (step_q == KS_WAIT1 && !open));

  a_r9_relock_closes: assert property (@(posedge clk) disable iff (rst)
    relock |=> !open);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_key_pkg::*;
#(
  parameter int          NGPIO    = 16,
  parameter logic [15:0] CHIP_ID  = 16'h8761,
  parameter logic [15:0] DEF_BASE = 16'h0A00,
  localparam int         NBANK    = NGPIO / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open,
  input  logic             idx_wr,
  input  logic             dat_wr,
  input  logic [7:0]       wdata,
  output logic [7:0]       idx_val,
  output logic [7:0]       dat_val,
  output logic             relock,
  output logic [15:0]      rt_base,
  output logic [NGPIO-1:0] gpio_dir
);
  logic [7:0] idx_q;
  logic [7:0] dev_q;
  logic [7:0] dir_q [NBANK];
  logic       dev_on;
  logic       wr_ok;

  assign dev_on  = (dev_q == DEV_GPIO);
  assign wr_ok   = open && dat_wr;
  assign relock  = wr_ok && (idx_q == IDX_EXIT) && (wdata == EXIT_VAL);
  assign idx_val = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= 8'h00;
      dev_q <= 8'h00;
    end else begin
      if (open && idx_wr) idx_q <= wdata;
      if (wr_ok && idx_q == IDX_DEV) dev_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rt_base <= DEF_BASE;
    end else if (wr_ok && dev_on) begin
      if (idx_q == IDX_BA_HI) rt_base[15:8] <= wdata;
      if (idx_q == IDX_BA_LO) rt_base[7:0]  <= wdata;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [7:0] BANK_IDX = 8'(IDX_DIR0 + b);
    always_ff @(posedge clk) begin
      if (rst) begin
        dir_q[b] <= 8'h00;
      end else if (wr_ok && dev_on && idx_q == BANK_IDX) begin
        dir_q[b] <= wdata;
      end
    end
    assign gpio_dir[8*b +: 8] = dir_q[b];
  end

  always_comb begin
    dat_val = 8'h00;
    case (idx_q)
      IDX_DEV:   dat_val = dev_q;
      IDX_ID_HI: dat_val = CHIP_ID[15:8];
      IDX_ID_LO: dat_val = CHIP_ID[7:0];
      IDX_BA_HI: if (dev_on) dat_val = rt_base[15:8];
      IDX_BA_LO: if (dev_on) dat_val = rt_base[7:0];
      default:   dat_val = 8'h00;
    endcase
    for (int b = 0; b < NBANK; b++) begin
      if (dev_on && idx_q == 8'(IDX_DIR0 + b)) dat_val = dir_q[b];
    end
  end

  a_r4_dir_frozen_locked: assert property (@(posedge clk) disable iff (rst)
    !open |=> $stable(gpio_dir));

  a_r4_base_frozen_locked: assert property (@(posedge clk) disable iff (rst)
    !open |=> $stable(rt_base));

  a_r6_unselected_dir_kept: assert property (@(posedge clk) disable iff (rst)
    !dev_on |=> $stable(gpio_dir));
endmodule

// File: rtl/cfg_key_port.sv
module cfg_key_port
  import cfg_key_pkg::*;
#(
  parameter logic [15:0] PORT_ADDR = 16'h002E,
  parameter logic [15:0] CHIP_ID   = 16'h8761,
  parameter logic [15:0] DEF_BASE  = 16'h0A00,
  parameter int          NGPIO     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [15:0]      io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  output logic [15:0]      rt_base,
  output logic [NGPIO-1:0] gpio_dir
);
  localparam logic [15:0] DATA_ADDR = PORT_ADDR + 16'd1;
  localparam logic [7:0]  KEY_LAST  =
    (PORT_ADDR == 16'h004E) ? KEY_LAST_HI : KEY_LAST_LO;

  logic       at_idx, at_dat;
  logic       open;
  logic       relock;
  logic [7:0] idx_val, dat_val;

  assign at_idx = (io_addr == PORT_ADDR);
  assign at_dat = (io_addr == DATA_ADDR);

  cfg_key_matcher #(.LAST_BYTE(KEY_LAST)) u_key (
    .clk      (clk),
    .rst      (rst),
    .byte_vld (io_wr && at_idx),
    .byte_in  (io_wdata),
    .relock   (relock),
    .open     (open)
  );

  cfg_regfile #(
    .NGPIO    (NGPIO),
    .CHIP_ID  (CHIP_ID),
    .DEF_BASE (DEF_BASE)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .open     (open),
    .idx_wr   (io_wr && at_idx),
    .dat_wr   (io_wr && at_dat),
    .wdata    (io_wdata),
    .idx_val  (idx_val),
    .dat_val  (dat_val),
    .relock   (relock),
    .rt_base  (rt_base),
    .gpio_dir (gpio_dir)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= LOCKED_RD;
    end else if (io_rd && (at_idx || at_dat)) begin
      if (!open)       io_rdata <= LOCKED_RD;
      else if (at_idx) io_rdata <= idx_val;
      else             io_rdata <= dat_val;
    end
  end

  a_r4_locked_read_ff: assert property (@(posedge clk) disable iff (rst)
    (!open && io_rd && at_dat) |=> io_rdata == LOCKED_RD);

  a_r5_id_high_byte: assert property (@(posedge clk) disable iff (rst)
    (open && io_rd && at_dat && idx_val == IDX_ID_HI) |=> io_rdata == CHIP_ID[15:8]);

  a_r5_id_low_byte: assert property (@(posedge clk) disable iff (rst)
    (open && io_rd && at_dat && idx_val == IDX_ID_LO) |=> io_rdata == CHIP_ID[7:0]);

  a_r10_other_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (!at_idx && !at_dat) |=> $stable(io_rdata));
endmodule

// File: tb/cfg_key_port_test.sv
module cfg_key_port_test;
  localparam logic [15:0] PA = 16'h002E;
  localparam logic [15:0] PB = 16'h004E;
  localparam logic [15:0] DEF_BASE = 16'h0A00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  rdata_a, rdata_b;
  logic [15:0] base_a, base_b, dir_a, dir_b;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  cfg_key_port #(.PORT_ADDR(PA), .DEF_BASE(DEF_BASE)) uut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(rdata_a), .rt_base(base_a), .gpio_dir(dir_a));

  cfg_key_port #(.PORT_ADDR(PB), .DEF_BASE(DEF_BASE)) uut_alt (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(rdata_b), .rt_base(base_b), .gpio_dir(dir_b));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_addr = 16'h0000;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0; io_addr = 16'h0000;
    v = (a == PB || a == PB + 16'd1) ? rdata_b : rdata_a;
  endtask

  task automatic rreg(input logic [15:0] p, input logic [7:0] idx, output logic [7:0] v);
    wr(p, idx);
    rd(p + 16'd1, v);
  endtask

  task automatic wreg(input logic [15:0] p, input logic [7:0] idx, input logic [7:0] d);
    wr(p, idx);
    wr(p + 16'd1, d);
  endtask

  task automatic unlock(input logic [15:0] p);
    wr(p, 8'h87); wr(p, 8'h61); wr(p, 8'h55);
    wr(p, (p == PB) ? 8'hAA : 8'h55);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] last;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 dir", dir_a, 16'h0000);
    chk("R1 base", base_a, DEF_BASE);
    chk("R1 alt base", base_b, DEF_BASE);
    rd(PA + 16'd1, v); chk("R1 locked read", {8'h00, v}, 16'h00FF);

    // R4 locked writes ignored, reads FF
    wr(PA, 8'hF0); wr(PA + 16'd1, 8'hFF);
    chk("R4 dir untouched", dir_a, 16'h0000);
    rd(PA, v); chk("R4 locked index read", {8'h00, v}, 16'h00FF);

    // R2 sweep of final key byte at both addresses
    for (int p = 0; p < 2; p++) begin
      logic [15:0] port;
      port = (p == 0) ? PA : PB;
      last = (p == 0) ? 8'h55 : 8'hAA;
      for (int b = 0; b < 256; b++) begin
        wr(port, 8'h87); wr(port, 8'h61); wr(port, 8'h55); wr(port, 8'(b));
        rreg(port, 8'h20, v);
        chk("R2 key final byte", {8'(b), v}, {8'(b), (8'(b) == last) ? 8'h87 : 8'hFF});
        if (8'(b) == last) wreg(port, 8'h02, 8'h02);
      end
    end

    // R10 other instance unaffected by this address's key
    unlock(PA);
    rd(PB + 16'd1, v); chk("R10 alt stays locked", {8'h00, v}, 16'h00FF);
    wreg(PA, 8'h02, 8'h02);

    // R3 wrong 0x87 restarts at step two
    wr(PA, 8'h87); wr(PA, 8'h61); wr(PA, 8'h87); wr(PA, 8'h61); wr(PA, 8'h55); wr(PA, 8'h55);
    rreg(PA, 8'h21, v); chk("R3 restart via 87", {8'h00, v}, 16'h0061);
    wreg(PA, 8'h02, 8'h02);
    // R3 other wrong byte resets fully
    wr(PA, 8'h87); wr(PA, 8'h61); wr(PA, 8'h00); wr(PA, 8'h55); wr(PA, 8'h55);
    rreg(PA, 8'h21, v); chk("R3 reset on wrong byte", {8'h00, v}, 16'h00FF);

    // R5 chip id, read-only
    unlock(PA);
    rreg(PA, 8'h20, v); chk("R5 id high", {8'h00, v}, 16'h0087);
    wreg(PA, 8'h21, 8'h00);
    rreg(PA, 8'h21, v); chk("R5 id low read-only", {8'h00, v}, 16'h0061);

    // R10 index readback
    wr(PA, 8'h3C); rd(PA, v); chk("R10 index readback", {8'h00, v}, 16'h003C);

    // R6 device select gating
    wreg(PA, 8'h07, 8'h01);
    rreg(PA, 8'h07, v); chk("R6 select readback", {8'h00, v}, 16'h0001);
    wreg(PA, 8'hF0, 8'h5A);
    chk("R6 dir write discarded", dir_a, 16'h0000);
    rreg(PA, 8'h60, v); chk("R6 base hidden", {8'h00, v}, 16'h0000);
    wreg(PA, 8'h60, 8'h77);
    chk("R6 base write discarded", base_a, DEF_BASE);
    wreg(PA, 8'h07, 8'h02);
    rreg(PA, 8'h60, v); chk("R6 base visible", {8'h00, v}, {8'h00, DEF_BASE[15:8]});

    // R7 base address
    wreg(PA, 8'h60, 8'h12); wreg(PA, 8'h61, 8'h34);
    chk("R7 base out", base_a, 16'h1234);
    rreg(PA, 8'h61, v); chk("R7 low readback", {8'h00, v}, 16'h0034);

    // R8 exhaustive direction sweep on both banks
    for (int bank = 0; bank < 2; bank++) begin
      for (int d = 0; d < 256; d++) begin
        wreg(PA, 8'(8'hF0 + bank), 8'(d));
        if (bank == 0) chk("R8 low bank out", {8'h00, dir_a[7:0]}, 16'(d));
        else           chk("R8 high bank out", {8'h00, dir_a[15:8]}, 16'(d));
        rreg(PA, 8'(8'hF0 + bank), v);
        chk("R8 dir readback", {8'h00, v}, 16'(d));
      end
    end
    wreg(PA, 8'hF0, 8'hA5);
    chk("R8 both banks", dir_a, 16'hFFA5);

    // R9 relock and near miss
    wreg(PA, 8'h02, 8'h05);
    rreg(PA, 8'h20, v); chk("R9 near miss stays open", {8'h00, v}, 16'h0087);
    wreg(PA, 8'h02, 8'h02);
    rreg(PA, 8'h20, v); chk("R9 relocked", {8'h00, v}, 16'h00FF);
    wreg(PA, 8'hF0, 8'h00);
    chk("R9 dir kept after relock", dir_a, 16'hFFA5);
    unlock(PA);
    rreg(PA, 8'h21, v); chk("R9 reopen with key", {8'h00, v}, 16'h0061);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule